// File: doc/BRIEF.md
# Embedded Sync Code Decoder

This block takes a byte-wide video stream that carries no separate horizontal or vertical timing wires. Line and frame boundaries are marked inside the data itself. Each boundary is a four-byte group: one 0xFF, two 0x00, and then a marker byte that names the boundary. The decoder finds these groups and rebuilds frame and line timing from them. It also marks which of the remaining bytes are real picture samples.

Software programs four marker patterns: frame start, frame end, line start and line end. Each pattern has its own compare mask, so only the chosen marker bits must match. After the block is enabled, it keeps frame timing off until it has seen a frame-end code. Only a frame-start code that comes after that frame-end can open a frame. A capture path downstream uses the per-code pulses, the two activity levels and the strobed pixel bytes. The byte width is fixed at eight bits.

Top module: `esync_decoder`

## Requirements
- R1: While `rst` is high, or while `enable` is low, every pulse, `frame_active`, `line_active` and `pix_valid` read 0 after the next clock edge. Frame arming is cleared by the same condition.
- R2: An accepted byte sequence 0xFF, 0x00, 0x00, M is a sync code with marker M. The matching code pulse is high for exactly the one cycle after the edge that accepts M.
- R3: Code k matches marker M when (M xor value_k) and unmask_k is zero, so marker bits whose unmask bit is 0 are ignored. With line-start value 0xA5 and unmask 0xF0, marker 0xA6 is detected as line start.
- R4: When a marker matches several codes, only one pulse fires. Frame start wins over frame end, frame end wins over line start, and line start wins over line end.
- R5: A byte that breaks the 0xFF, 0x00, 0x00 prefix sends the search back to the start. Any 0xFF restarts the prefix, so 0xFF 0xFF 0x00 0x00 M is still a valid code.
- R6: `frame_active` rises only on a frame-start code, and only after a frame-end code has been seen since enable. A frame-start code before that still pulses but leaves `frame_active` low.
- R7: A line-start code sets `line_active` only while `frame_active` is 1. Line-end, frame-end and frame-start codes clear `line_active`.
- R8: An accepted byte other than 0xFF or 0x00, not in marker position, gives `pix_valid`=1 and `pix_data`=that byte one cycle later. This happens only when `frame_active` and `line_active` were both 1 at that edge. The 0xFF and 0x00 bytes are never reported as pixels.
- R9: A frame-end code clears `frame_active` at the same edge as its pulse.
- R10: A cycle with `in_valid` low changes no decoder state and produces no pulse and no pixel strobe.
- R11: A marker that matches no code produces no pulse and no pixel, and the search restarts at the next byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Decoder on; low clears all state |
| in_valid | input | 1 | Byte on `in_data` is accepted this cycle |
| in_data | input | 8 | Incoming stream byte |
| fs_value | input | 8 | Frame-start marker pattern |
| fs_unmask | input | 8 | Frame-start compare mask (1 = compare bit) |
| fe_value | input | 8 | Frame-end marker pattern |
| fe_unmask | input | 8 | Frame-end compare mask |
| ls_value | input | 8 | Line-start marker pattern |
| ls_unmask | input | 8 | Line-start compare mask |
| le_value | input | 8 | Line-end marker pattern |
| le_unmask | input | 8 | Line-end compare mask |
| fs_pulse | output | 1 | Frame-start code seen |
| fe_pulse | output | 1 | Frame-end code seen |
| ls_pulse | output | 1 | Line-start code seen |
| le_pulse | output | 1 | Line-end code seen |
| frame_active | output | 1 | Rebuilt frame window |
| line_active | output | 1 | Rebuilt line window |
| pix_valid | output | 1 | `pix_data` holds a picture byte this cycle |
| pix_data | output | 8 | Picture byte |

## Verification
The assertions take two things for granted. First, picture bytes never use 0xFF or 0x00, so those values only ever start a sync group. Second, the marker configuration does not change while a marker byte is being accepted. The stimulus uses only picture bytes outside the reserved pair. It changes the mask and value inputs only in idle gaps between codes, with `in_valid` low. Broken prefixes, repeated 0xFF and unmatched markers are injected on purpose, because the decoder must recover from them.

// File: rtl/esd_pkg.sv
package esd_pkg;

    localparam int BYTE_W    = 8;
    localparam int NUM_CODES = 4;
    localparam int CODE_IDX_W = $clog2(NUM_CODES);

    localparam logic [BYTE_W-1:0] LEAD_BYTE = {BYTE_W{1'b1}};
    localparam logic [BYTE_W-1:0] FILL_BYTE = {BYTE_W{1'b0}};

    // Index order is also the match priority (lowest index wins).
    localparam int IDX_FS = 0;
    localparam int IDX_FE = 1;
    localparam int IDX_LS = 2;
    localparam int IDX_LE = 3;

    typedef enum logic [1:0] {
        SEEK     = 2'd0,
        SAW_LEAD = 2'd1,
        SAW_FILL = 2'd2,
        AT_MARK  = 2'd3
    } prefix_e;

    typedef enum logic [2:0] {
        CODE_NONE = 3'd0,
        CODE_FS   = 3'd1,
        CODE_FE   = 3'd2,
        CODE_LS   = 3'd3,
        CODE_LE   = 3'd4
    } code_e;

    typedef struct packed {
        logic [BYTE_W-1:0] value;
        logic [BYTE_W-1:0] unmask;
    } marker_cfg_t;

    typedef struct packed {
        logic fs;
        logic fe;
        logic ls;
        logic le;
    } pulse_t;

    function automatic logic marker_hit(input logic [BYTE_W-1:0] b,
                                        input marker_cfg_t c);
        return ((b ^ c.value) & c.unmask) == '0;
    endfunction

    function automatic logic is_reserved(input logic [BYTE_W-1:0] b);
        return (b == LEAD_BYTE) || (b == FILL_BYTE);
    endfunction

    function automatic prefix_e prefix_next(input prefix_e s,
                                            input logic [BYTE_W-1:0] b);
        prefix_e n;
        if (b == LEAD_BYTE)
            n = SAW_LEAD;
        else if (b == FILL_BYTE && s == SAW_LEAD)
            n = SAW_FILL;
        else if (b == FILL_BYTE && s == SAW_FILL)
            n = AT_MARK;
        else
            n = SEEK;
        return n;
    endfunction

    function automatic code_e code_of_index(input int idx);
        code_e c;
        case (idx)
            IDX_FS:  c = CODE_FS;
            IDX_FE:  c = CODE_FE;
            IDX_LS:  c = CODE_LS;
            default: c = CODE_LE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/esd_prefix_tracker.sv
module esd_prefix_tracker
    import esd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    output logic              marker_slot,
    output logic              payload_byte
);

    prefix_e st;

    always_ff @(posedge clk) begin
        if (rst || !enable)
            st <= SEEK;
        else if (byte_valid)
            st <= (st == AT_MARK) ? SEEK : prefix_next(st, byte_data);
    end

    assign marker_slot  = byte_valid && (st == AT_MARK);
    assign payload_byte = byte_valid && (st != AT_MARK) && !is_reserved(byte_data);

    // R2: marker position is only reached after two fill bytes following a lead
    p_marker_after_prefix_r2: assert property (@(posedge clk) disable iff (rst)
        (st == AT_MARK && $past(st) != AT_MARK) |->
            ($past(st) == SAW_FILL && $past(byte_valid) && $past(byte_data) == FILL_BYTE));

    // R10: an idle cycle leaves the search state untouched
    p_stall_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!byte_valid && enable) |=> $stable(st));

    // R5: a lead byte always restarts the prefix
    p_lead_restart_r5: assert property (@(posedge clk) disable iff (rst)
        (enable && byte_valid && st != AT_MARK && byte_data == LEAD_BYTE) |=> (st == SAW_LEAD));

endmodule

// File: rtl/esd_marker_classifier.sv
module esd_marker_classifier
    import esd_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_data,
    input  marker_cfg_t       cfg [NUM_CODES],
    output logic [NUM_CODES-1:0] hit_vec,
    output code_e             code
);

    for (genvar g = 0; g < NUM_CODES; g++) begin : g_cmp
        assign hit_vec[g] = marker_hit(byte_data, cfg[g]);
    end

    always_comb begin
        code = CODE_NONE;
        for (int i = NUM_CODES - 1; i >= 0; i--) begin
            if (hit_vec[i])
                code = code_of_index(i);
        end
    end

endmodule

// File: rtl/esd_timing_gen.sv
module esd_timing_gen
    import esd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              marker_slot,
    input  logic              payload_byte,
    input  code_e             code,
    input  logic [BYTE_W-1:0] byte_data,
    output pulse_t            pulses,
    output logic              frame_active,
    output logic              line_active,
    output logic              pix_valid,
    output logic [BYTE_W-1:0] pix_data
);

    logic armed;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            pulses       <= '0;
            armed        <= 1'b0;
            frame_active <= 1'b0;
            line_active  <= 1'b0;
            pix_valid    <= 1'b0;
            pix_data     <= '0;
        end else begin
            pulses    <= '0;
            pix_valid <= 1'b0;
            if (marker_slot) begin
                unique case (code)
                    CODE_FS: begin
                        pulses.fs   <= 1'b1;
                        line_active <= 1'b0;
                        if (armed)
                            frame_active <= 1'b1;
                    end
                    CODE_FE: begin
                        pulses.fe    <= 1'b1;
                        armed        <= 1'b1;
                        frame_active <= 1'b0;
                        line_active  <= 1'b0;
                    end
                    CODE_LS: begin
                        pulses.ls <= 1'b1;
                        if (frame_active)
                            line_active <= 1'b1;
                    end
                    CODE_LE: begin
                        pulses.le   <= 1'b1;
                        line_active <= 1'b0;
                    end
                    default: ;
                endcase
            end
            if (payload_byte && frame_active && line_active) begin
                pix_valid <= 1'b1;
                pix_data  <= byte_data;
            end
        end
    end

    // R4: never more than one code pulse in a cycle
    p_single_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pulses));

    // R7: the line window lies inside the frame window
    p_line_in_frame_r7: assert property (@(posedge clk) disable iff (rst)
        line_active |-> frame_active);

    // R6: the frame window only opens on a frame-start code
    p_frame_open_on_fs_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_active) |-> pulses.fs);

    // R9: frame end closes the frame window
    p_fe_closes_r9: assert property (@(posedge clk) disable iff (rst)
        pulses.fe |-> !frame_active);

    // R8: reserved bytes are never strobed as pixels
    p_pix_not_reserved_r8: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> !is_reserved(pix_data));

    // R8: a pixel is only strobed from inside a line
    p_pix_in_line_r8: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> $past(line_active));

    // R1: disable empties all timing state
    p_disable_clears_r1: assert property (@(posedge clk) disable iff (rst)
        $past(!enable) |-> (!frame_active && !line_active && !pix_valid && pulses == '0));

endmodule

// File: rtl/esync_decoder.sv
module esync_decoder
    import esd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic [BYTE_W-1:0] fs_value,
    input  logic [BYTE_W-1:0] fs_unmask,
    input  logic [BYTE_W-1:0] fe_value,
    input  logic [BYTE_W-1:0] fe_unmask,
    input  logic [BYTE_W-1:0] ls_value,
    input  logic [BYTE_W-1:0] ls_unmask,
    input  logic [BYTE_W-1:0] le_value,
    input  logic [BYTE_W-1:0] le_unmask,
    output logic              fs_pulse,
    output logic              fe_pulse,
    output logic              ls_pulse,
    output logic              le_pulse,
    output logic              frame_active,
    output logic              line_active,
    output logic              pix_valid,
    output logic [BYTE_W-1:0] pix_data
);

    marker_cfg_t          cfg [NUM_CODES];
    logic                 marker_slot;
    logic                 payload_byte;
    logic [NUM_CODES-1:0] hit_vec;
    code_e                code;
    pulse_t               pulses;

    assign cfg[IDX_FS] = '{value: fs_value, unmask: fs_unmask};
    assign cfg[IDX_FE] = '{value: fe_value, unmask: fe_unmask};
    assign cfg[IDX_LS] = '{value: ls_value, unmask: ls_unmask};
    assign cfg[IDX_LE] = '{value: le_value, unmask: le_unmask};

    esd_prefix_tracker u_prefix (
        .clk          (clk),
        .rst          (rst),
        .enable       (enable),
        .byte_valid   (in_valid),
        .byte_data    (in_data),
        .marker_slot  (marker_slot),
        .payload_byte (payload_byte)
    );

    esd_marker_classifier u_class (
        .byte_data (in_data),
        .cfg       (cfg),
        .hit_vec   (hit_vec),
        .code      (code)
    );

    esd_timing_gen u_timing (
        .clk          (clk),
        .rst          (rst),
        .enable       (enable),
        .marker_slot  (marker_slot),
        .payload_byte (payload_byte),
        .code         (code),
        .byte_data    (in_data),
        .pulses       (pulses),
        .frame_active (frame_active),
        .line_active  (line_active),
        .pix_valid    (pix_valid),
        .pix_data     (pix_data)
    );

    assign fs_pulse = pulses.fs;
    assign fe_pulse = pulses.fe;
    assign ls_pulse = pulses.ls;
    assign le_pulse = pulses.le;

    // R11 / R3: a pulse requires a marker slot whose byte hit at least one code
    p_pulse_needs_hit_r11: assert property (@(posedge clk) disable iff (rst)
        (fs_pulse || fe_pulse || ls_pulse || le_pulse) |->
            $past(marker_slot && hit_vec != '0));

endmodule

// File: tb/esync_decoder_tb_top.sv
module esync_decoder_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic [7:0] fs_value = 8'hAB, fs_unmask = 8'hFF;
    logic [7:0] fe_value = 8'hB6, fe_unmask = 8'hFF;
    logic [7:0] ls_value = 8'hA5, ls_unmask = 8'hF0;
    logic [7:0] le_value = 8'h9D, le_unmask = 8'hFF;
    logic       fs_pulse, fe_pulse, ls_pulse, le_pulse;
    logic       frame_active, line_active, pix_valid;
    logic [7:0] pix_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    int         m_prefix = 0;
    bit         m_armed = 0, m_fa = 0, m_la = 0;
    bit         m_fs = 0, m_fe = 0, m_ls = 0, m_le = 0, m_pv = 0;
    logic [7:0] m_pd = 8'h00;

    esync_decoder dut_i (
        .clk(clk), .rst(rst), .enable(enable), .in_valid(in_valid), .in_data(in_data),
        .fs_value(fs_value), .fs_unmask(fs_unmask), .fe_value(fe_value), .fe_unmask(fe_unmask),
        .ls_value(ls_value), .ls_unmask(ls_unmask), .le_value(le_value), .le_unmask(le_unmask),
        .fs_pulse(fs_pulse), .fe_pulse(fe_pulse), .ls_pulse(ls_pulse), .le_pulse(le_pulse),
        .frame_active(frame_active), .line_active(line_active),
        .pix_valid(pix_valid), .pix_data(pix_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // returns 0..3 for FS,FE,LS,LE in priority order, -1 for no match
    function automatic int classify(input logic [7:0] b);
        logic [7:0] v [4];
        logic [7:0] k [4];
        v[0] = fs_value; k[0] = fs_unmask;
        v[1] = fe_value; k[1] = fe_unmask;
        v[2] = ls_value; k[2] = ls_unmask;
        v[3] = le_value; k[3] = le_unmask;
        for (int i = 0; i < 4; i++)
            if ((b & k[i]) == (v[i] & k[i])) return i;
        return -1;
    endfunction

    task automatic model_edge(input bit v, input logic [7:0] b);
        m_fs = 0; m_fe = 0; m_ls = 0; m_le = 0; m_pv = 0;
        if (rst || !enable) begin
            m_prefix = 0; m_armed = 0; m_fa = 0; m_la = 0; m_pd = 8'h00;
        end else if (v) begin
            if (m_prefix == 3) begin
                case (classify(b))
                    0: begin m_fs = 1; m_la = 0; if (m_armed) m_fa = 1; end
                    1: begin m_fe = 1; m_armed = 1; m_fa = 0; m_la = 0; end
                    2: begin m_ls = 1; if (m_fa) m_la = 1; end
                    3: begin m_le = 1; m_la = 0; end
                    default: ;
                endcase
                m_prefix = 0;
            end else begin
                if (b != 8'hFF && b != 8'h00 && m_fa && m_la) begin
                    m_pv = 1; m_pd = b;
                end
                if (b == 8'hFF)                      m_prefix = 1;
                else if (b == 8'h00 && m_prefix > 0) m_prefix = m_prefix + 1;
                else                                 m_prefix = 0;
            end
        end
    endtask

    task automatic compare_all();
        chk(fs_pulse == m_fs, "R2 fs_pulse", fs_pulse, m_fs);
        chk(fe_pulse == m_fe, "R2 fe_pulse", fe_pulse, m_fe);
        chk(ls_pulse == m_ls, "R2 ls_pulse", ls_pulse, m_ls);
        chk(le_pulse == m_le, "R2 le_pulse", le_pulse, m_le);
        chk(frame_active == m_fa, "R6 frame_active", frame_active, m_fa);
        chk(line_active == m_la, "R7 line_active", line_active, m_la);
        chk(pix_valid == m_pv, "R8 pix_valid", pix_valid, m_pv);
        if (m_pv) chk(pix_data == m_pd, "R8 pix_data", pix_data, m_pd);
    endtask

    task automatic step(input bit v, input logic [7:0] b);
        @(negedge clk);
        in_valid = v;
        in_data  = b;
        model_edge(v, b);
        @(posedge clk);
        #1;
        compare_all();
    endtask

    task automatic code(input logic [7:0] m);
        step(1, 8'hFF); step(1, 8'h00); step(1, 8'h00); step(1, m);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stimulus
        // R1: reset state
        rst = 1; enable = 0;
        repeat (3) step(0, 8'h00);
        chk(!frame_active && !line_active && !pix_valid && !fs_pulse, "R1 reset state",
            {frame_active, line_active, pix_valid, fs_pulse}, 0);
        @(negedge clk); rst = 0; enable = 1;
        step(0, 8'h00);

        // R6: frame start before any frame end does not open a frame
        step(1, 8'h31); step(1, 8'h42);
        code(8'hAB);
        chk(fs_pulse == 1, "R6 early fs still pulses", fs_pulse, 1);
        chk(frame_active == 0, "R6 early fs not armed", frame_active, 0);

        // R6/R9: FE then FS opens the frame
        code(8'hB6);
        chk(fe_pulse == 1 && frame_active == 0, "R9 fe pulse frame low", {fe_pulse, frame_active}, 2);
        code(8'hAB);
        chk(frame_active == 1, "R6 fe then fs opens frame", frame_active, 1);

        // R3: masked compare, A6 seen as line start
        code(8'hA6);
        chk(ls_pulse == 1 && line_active == 1, "R3 masked line start", {ls_pulse, line_active}, 3);

        // R8/R10: pixels with idle gaps
        step(1, 8'h12);
        chk(pix_valid == 1 && pix_data == 8'h12, "R8 pixel strobe", pix_data, 8'h12);
        step(0, 8'h77);
        chk(pix_valid == 0, "R10 idle cycle no strobe", pix_valid, 0);
        step(1, 8'hFF); step(0, 8'h00); step(0, 8'h00); step(1, 8'h00); step(1, 8'h00);
        step(1, 8'h34);
        chk(ls_pulse == 0 && pix_valid == 0, "R10 stalled prefix still forms marker",
            {ls_pulse, pix_valid}, 0);

        // R5: broken prefix then double lead
        step(1, 8'h56);
        step(1, 8'hFF); step(1, 8'h00); step(1, 8'h13);
        chk(pix_valid == 1 && pix_data == 8'h13, "R5 broken prefix byte is data", pix_data, 8'h13);
        step(1, 8'hFF);
        code(8'h9D);
        chk(le_pulse == 1 && line_active == 0, "R5 double lead code", {le_pulse, line_active}, 2);

        // R11: unmatched marker
        code(8'hA5);
        code(8'h01);
        chk({fs_pulse, fe_pulse, ls_pulse, le_pulse, pix_valid} == 0, "R11 unmatched marker",
            {fs_pulse, fe_pulse, ls_pulse, le_pulse, pix_valid}, 0);
        step(1, 8'h22);
        chk(pix_valid == 1 && pix_data == 8'h22, "R11 search resumes", pix_data, 8'h22);

        // R7: line end clears, line start outside frame ignored later
        code(8'h9D);
        step(1, 8'h23);
        chk(pix_valid == 0, "R7 no pixel after line end", pix_valid, 0);

        // R9: frame end closes frame
        code(8'hA5); step(1, 8'h24);
        code(8'hB6);
        chk(frame_active == 0 && line_active == 0, "R9 frame end closes", {frame_active, line_active}, 0);
        code(8'hA5);
        chk(ls_pulse == 1 && line_active == 0, "R7 line start outside frame", {ls_pulse, line_active}, 2);

        // R4: priority with all masks cleared
        @(negedge clk); in_valid = 0;
        fs_unmask = 8'h00; fe_unmask = 8'h00; ls_unmask = 8'h00; le_unmask = 8'h00;
        code(8'h55);
        chk(fs_pulse && !fe_pulse && !ls_pulse && !le_pulse, "R4 fs wins",
            {fs_pulse, fe_pulse, ls_pulse, le_pulse}, 8);
        @(negedge clk); in_valid = 0; fs_unmask = 8'hFF;
        code(8'h55);
        chk(fe_pulse && !ls_pulse, "R4 fe beats line codes", {fe_pulse, ls_pulse}, 2);
        @(negedge clk); in_valid = 0; fe_unmask = 8'hFF;
        code(8'h55);
        chk(ls_pulse && !le_pulse, "R4 ls beats le", {ls_pulse, le_pulse}, 2);
        @(negedge clk); in_valid = 0; ls_unmask = 8'hF0; le_unmask = 8'hFF;

        // R1/R6: disable clears arming
        code(8'hB6); code(8'hAB); code(8'hA5);
        chk(line_active == 1, "R7 line open before disable", line_active, 1);
        @(negedge clk); enable = 0;
        step(0, 8'h00);
        chk(!frame_active && !line_active, "R1 disable clears", {frame_active, line_active}, 0);
        @(negedge clk); enable = 1;
        code(8'hAB);
        chk(frame_active == 0, "R6 arming lost after disable", frame_active, 0);

        // longer mixed traffic, compared each cycle
        code(8'hB6); code(8'hAB);
        for (int ln = 0; ln < 6; ln++) begin
            code(8'hA5);
            for (int p = 0; p < 10; p++) step((p % 3) != 2, 8'h10 + 8'(ln * 16 + p));
            code(8'h9D);
        end
        code(8'hB6);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule